// File: doc/BRIEF.md
# Interlocked Ring Node Interface

This block is the communication port of one processing node on a one-way word ring. Each node owns a single receive register, loaded from the node on its left, and a single send register, which the node on its right loads from. Between two neighbours there are a data bus and two handshake lines. One line runs forward and says "my send register holds a word". The other runs backward and says "my receive register is occupied". A word moves from the sender's send register into the receiver's receive register on the clock edge where the first line is high and the second is low. Both nodes work this out from the same registered values, so neither needs a reply from the other within the cycle.

The local processor issues one of four operation codes and waits on a ready line. A get reads the next incoming word. A put places a word toward the right neighbour. A shift reads the incoming word and also queues it for the right neighbour. Ready is decoded from four registers: the local receive and send registers, the left neighbour's send register and the right neighbour's receive register. An operation completes on the edge where ready is high, and the processor holds its request until then.

When the receive register is empty and the left neighbour offers a word, a get or shift reads that word straight off the ring bus. Because of this bypass, a steady stream moves one word per cycle. To broadcast on N nodes, every node puts its own word and then does N-2 shifts followed by one get. After that, every node has seen every other node's word.

Top module: `ring_link_node`

## Requirements
- R1: After reset both registers are empty, so `up_full_o` and `dn_valid_o` are 0, and a get with no upstream word is not ready.
- R2: Operation code 1 (get) is ready exactly when the receive register is full or `up_valid_i` is 1. `rdata_o` then carries the receive register's word if it is full, and `up_data_i` otherwise (bypass). In the bypass case the receive register stays empty after the edge.
- R3: Operation code 2 (put) is ready exactly when the send register is empty or `dn_full_i` is 0. After the completing edge, `dn_valid_o` is 1 and `dn_data_o` equals the word put.
- R4: Operation code 3 (shift) is ready exactly when the get condition and the put condition both hold. After the completing edge, `dn_data_o` equals the word that was read and `dn_valid_o` is 1.
- R5: A word moves from upstream into the receive register on an edge where `up_valid_i`=1, `up_full_o`=0 and no bypass read takes it. The send register empties on an edge where `dn_valid_o`=1 and `dn_full_i`=0, unless it is refilled on that edge. A register that neither loads nor empties holds its word.
- R6: Words leave a node in arrival order. A word in the receive register is always read before the upstream word that follows it.
- R7: Operation code 0 (idle) never raises ready and changes no register except through R5 transfers.
- R8: With the receive register empty and upstream offering a new word every cycle, consecutive gets complete every cycle and return the words in order.
- R9: On a ring of N nodes where each node does one put, N-2 shifts and one get, node k receives the words of nodes k-1, k-2, ..., k-(N-1) (mod N) in that order, each exactly once. Afterwards every register on the ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation: 0 idle, 1 get, 2 put, 3 shift |
| wdata_i | input | DATA_W | Word for a put |
| ready_o | output | 1 | Requested operation completes on this edge |
| rdata_o | output | DATA_W | Word read by a get or shift |
| up_data_i | input | DATA_W | Left neighbour's send register |
| up_valid_i | input | 1 | Left neighbour's send register is full |
| up_full_o | output | 1 | Local receive register is full (to left neighbour) |
| dn_data_o | output | DATA_W | Local send register (to right neighbour) |
| dn_valid_o | output | 1 | Local send register is full |
| dn_full_i | input | 1 | Right neighbour's receive register is full |

## Verification
The hardest situation to reach is the send register refilling on the same edge as it drains. This occurs while every node on the ring shifts at once, and the neighbours' register states must line up for it. The bench reaches it in two ways. First, a 64-point sweep places the node in each combination of receive-full, send-full, upstream-valid and downstream-full under each operation code, and compares ready with a formula. Second, a four-node ring runs a complete broadcast with all nodes issuing their put/shift/get sequences together. Each received word is compared with the word that ring arithmetic predicts.

// File: rtl/ring_link_pkg.sv
package ring_link_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE  = 2'd0,
        OP_GET   = 2'd1,
        OP_PUT   = 2'd2,
        OP_SHIFT = 2'd3
    } ring_op_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/ring_slot.sv
module ring_slot
    import ring_link_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic              drain_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    slot_state_e       state_q;
    slot_state_e       state_d;
    logic [DATA_W-1:0] data_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (fill_i) state_d = SLOT_FULL;
            end
            SLOT_FULL: begin
                if (drain_i && !fill_i) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // word storage
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (fill_i) data_q <= fill_data_i;
    end

    // outputs
    always_comb begin
        full_o = (state_q == SLOT_FULL);
        data_o = data_q;
    end

endmodule

// File: rtl/ring_op_ctrl.sv
module ring_op_ctrl
    import ring_link_pkg::*;
(
    input  ring_op_e op_i,
    input  logic     in_full_i,
    input  logic     up_valid_i,
    input  logic     out_full_i,
    input  logic     dn_full_i,
    output logic     ready_o,
    output logic     take_o,
    output logic     send_o,
    output logic     send_local_o
);

    logic have_word;
    logic out_free;

    always_comb begin
        have_word = in_full_i | up_valid_i;
        out_free  = ~out_full_i | ~dn_full_i;
    end

    always_comb begin
        ready_o      = 1'b0;
        take_o       = 1'b0;
        send_o       = 1'b0;
        send_local_o = 1'b0;
        unique case (op_i)
            OP_IDLE: begin
                ready_o = 1'b0;
            end
            OP_GET: begin
                ready_o = have_word;
                take_o  = have_word;
            end
            OP_PUT: begin
                ready_o      = out_free;
                send_o       = out_free;
                send_local_o = 1'b1;
            end
            OP_SHIFT: begin
                ready_o = have_word & out_free;
                take_o  = have_word & out_free;
                send_o  = have_word & out_free;
            end
            default: ready_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ring_link_node.sv
module ring_link_node
    import ring_link_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [DATA_W-1:0] up_data_i,
    input  logic              up_valid_i,
    output logic              up_full_o,
    output logic [DATA_W-1:0] dn_data_o,
    output logic              dn_valid_o,
    input  logic              dn_full_i
);

    ring_op_e          op;
    logic              in_full;
    logic [DATA_W-1:0] in_data;
    logic              out_full;
    logic [DATA_W-1:0] out_data;
    logic              take;
    logic              send;
    logic              send_local;
    logic              ready;
    logic [DATA_W-1:0] rd_word;
    logic              in_fill;
    logic              in_drain;
    logic              out_drain;
    logic [DATA_W-1:0] out_word;

    assign op = ring_op_e'(op_i);

    ring_op_ctrl u_ctrl (
        .op_i         (op),
        .in_full_i    (in_full),
        .up_valid_i   (up_valid_i),
        .out_full_i   (out_full),
        .dn_full_i    (dn_full_i),
        .ready_o      (ready),
        .take_o       (take),
        .send_o       (send),
        .send_local_o (send_local)
    );

    always_comb begin
        rd_word   = in_full ? in_data : up_data_i;
        in_fill   = up_valid_i & ~in_full & ~take;
        in_drain  = take & in_full;
        out_drain = out_full & ~dn_full_i;
        out_word  = send_local ? wdata_i : rd_word;
    end

    ring_slot #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_i      (in_fill),
        .fill_data_i (up_data_i),
        .drain_i     (in_drain),
        .full_o      (in_full),
        .data_o      (in_data)
    );

    ring_slot #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_i      (send),
        .fill_data_i (out_word),
        .drain_i     (out_drain),
        .full_o      (out_full),
        .data_o      (out_data)
    );

    always_comb begin
        ready_o    = ready;
        rdata_o    = rd_word;
        up_full_o  = in_full;
        dn_data_o  = out_data;
        dn_valid_o = out_full;
    end

endmodule

// File: rtl/ring_link_node_chk.sv
module ring_link_node_chk
    import ring_link_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              ready_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic [DATA_W-1:0] up_data_i,
    input logic              up_valid_i,
    input logic              up_full_o,
    input logic [DATA_W-1:0] dn_data_o,
    input logic              dn_valid_o,
    input logic              dn_full_i
);

    logic reading;
    assign reading = ready_o && (op_i == OP_GET || op_i == OP_SHIFT);

    AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_IDLE |-> !ready_o); // R7

    AST_GET_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_GET && !up_full_o && !up_valid_i) |-> !ready_o); // R2

    AST_PUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUT && dn_valid_o && dn_full_i) |-> !ready_o); // R3

    AST_PUT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && op_i == OP_PUT) |=> (dn_valid_o && dn_data_o == $past(wdata_i))); // R3

    AST_SHIFT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SHIFT && !up_full_o && !up_valid_i) |-> !ready_o); // R4

    AST_SHIFT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && op_i == OP_SHIFT) |=> (dn_valid_o && dn_data_o == $past(rdata_o))); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid_o && dn_full_i) |=> (dn_valid_o && $stable(dn_data_o))); // R5

    AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_full_o && !reading) |=> (up_full_o && $stable(rdata_o))); // R5

    AST_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_full_o && up_valid_i && !reading) |=> (up_full_o && rdata_o == $past(up_data_i))); // R5

endmodule

bind ring_link_node ring_link_node_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .wdata_i    (wdata_i),
    .ready_o    (ready_o),
    .rdata_o    (rdata_o),
    .up_data_i  (up_data_i),
    .up_valid_i (up_valid_i),
    .up_full_o  (up_full_o),
    .dn_data_o  (dn_data_o),
    .dn_valid_o (dn_valid_o),
    .dn_full_i  (dn_full_i)
);

// File: tb/ring_link_node_bench.sv
`timescale 1ns/1ps
module ring_link_node_bench;

    localparam int DW    = 32;
    localparam int NODES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // single node driven directly
    logic [1:0]    op = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic          ready;
    logic [DW-1:0] rdata;
    logic [DW-1:0] up_data = '0;
    logic          up_valid = 1'b0;
    logic          up_full;
    logic [DW-1:0] dn_data;
    logic          dn_valid;
    logic          dn_full = 1'b0;

    ring_link_node #(.DATA_W(DW)) u_ring_link_node (
        .clk(clk), .rst_n(rst_n), .op_i(op), .wdata_i(wdata),
        .ready_o(ready), .rdata_o(rdata),
        .up_data_i(up_data), .up_valid_i(up_valid), .up_full_o(up_full),
        .dn_data_o(dn_data), .dn_valid_o(dn_valid), .dn_full_i(dn_full)
    );

    // ring of nodes for the broadcast
    logic [1:0]    b_op    [NODES];
    logic [DW-1:0] b_wdata [NODES];
    logic          b_ready [NODES];
    logic [DW-1:0] b_rdata [NODES];
    logic [DW-1:0] b_dn_data  [NODES];
    logic          b_dn_valid [NODES];
    logic          b_up_full  [NODES];

    for (genvar gi = 0; gi < NODES; gi++) begin : g_ring
        ring_link_node #(.DATA_W(DW)) u_node (
            .clk(clk), .rst_n(rst_n), .op_i(b_op[gi]), .wdata_i(b_wdata[gi]),
            .ready_o(b_ready[gi]), .rdata_o(b_rdata[gi]),
            .up_data_i(b_dn_data[(gi+NODES-1)%NODES]),
            .up_valid_i(b_dn_valid[(gi+NODES-1)%NODES]),
            .up_full_o(b_up_full[gi]),
            .dn_data_o(b_dn_data[gi]), .dn_valid_o(b_dn_valid[gi]),
            .dn_full_i(b_up_full[(gi+1)%NODES])
        );
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op = 2'd0; up_valid = 1'b0; dn_full = 1'b0;
        for (int k = 0; k < NODES; k++) begin
            b_op[k] = 2'd0; b_wdata[k] = '0;
        end
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    function automatic logic [DW-1:0] node_word(input int k);
        return 32'hB0C0_0000 + DW'(k);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [DW-1:0] got [NODES][NODES];
        int            step [NODES];
        bit            rdy [NODES];
        logic [DW-1:0] rd [NODES];

        do_reset();

        // R1 reset state
        check(up_full == 1'b0, "R1 receive empty", DW'(up_full), 0);
        check(dn_valid == 1'b0, "R1 send empty", DW'(dn_valid), 0);
        op = 2'd1; #1;
        check(ready == 1'b0, "R1 get not ready", DW'(ready), 0);

        // R2/R3/R4/R7 sweep over every register combination and op code
        for (int i = 0; i < 64; i++) begin
            bit want_in, want_out, uv, df, have, free, exp_rdy;
            int o;
            want_in = i[0]; want_out = i[1]; uv = i[2]; df = i[3]; o = i[5:4];
            do_reset();
            op = want_out ? 2'd2 : 2'd0;
            wdata = 32'h0A00_0000 | DW'(i);
            up_valid = want_in; up_data = 32'h1100_0000 | DW'(i);
            dn_full = 1'b1;
            tick();
            up_valid = uv; up_data = 32'h2200_0000 | DW'(i);
            dn_full = df; op = 2'(o);
            #1;
            have = want_in | uv;
            free = !want_out | !df;
            case (o)
                0: exp_rdy = 1'b0;
                1: exp_rdy = have;
                2: exp_rdy = free;
                default: exp_rdy = have & free;
            endcase
            check(up_full == want_in && dn_valid == want_out, "R5 sweep setup",
                  DW'({up_full, dn_valid}), DW'({want_in, want_out}));
            check(ready == exp_rdy, (o == 0) ? "R7 idle ready" : (o == 1) ? "R2 get ready" :
                  (o == 2) ? "R3 put ready" : "R4 shift ready", DW'(ready), DW'(exp_rdy));
            if (exp_rdy && (o == 1 || o == 3))
                check(rdata == (want_in ? (32'h1100_0000 | DW'(i)) : (32'h2200_0000 | DW'(i))),
                      "R2 read source", rdata,
                      want_in ? (32'h1100_0000 | DW'(i)) : (32'h2200_0000 | DW'(i)));
        end

        // R5/R7: upstream word lands while idle and is held
        do_reset();
        up_valid = 1'b1; up_data = 32'hAAAA_0001; op = 2'd0;
        tick();
        up_valid = 1'b0;
        check(up_full == 1'b1, "R5 upstream word loaded", DW'(up_full), 1);
        tick(); tick();
        check(up_full == 1'b1, "R7 idle keeps word", DW'(up_full), 1);
        // R6 order: stored word first, then the following upstream word
        up_valid = 1'b1; up_data = 32'hAAAA_0002; op = 2'd1; #1;
        check(ready && rdata == 32'hAAAA_0001, "R6 stored word first", rdata, 32'hAAAA_0001);
        tick();
        check(up_full == 1'b0, "R5 no fill while full", DW'(up_full), 0);
        #1;
        check(ready && rdata == 32'hAAAA_0002, "R6 next word second", rdata, 32'hAAAA_0002);
        tick();
        up_valid = 1'b0; op = 2'd0;
        check(up_full == 1'b0, "R2 bypass leaves empty", DW'(up_full), 0);

        // R3 put, stall, hold and refill-on-drain
        op = 2'd2; wdata = 32'hC0DE_0001; dn_full = 1'b0;
        tick();
        check(dn_valid && dn_data == 32'hC0DE_0001, "R3 put lands", dn_data, 32'hC0DE_0001);
        dn_full = 1'b1; wdata = 32'hC0DE_0002; #1;
        check(ready == 1'b0, "R3 put stalls", DW'(ready), 0);
        tick();
        check(dn_data == 32'hC0DE_0001, "R5 send held", dn_data, 32'hC0DE_0001);
        dn_full = 1'b0; #1;
        check(ready == 1'b1, "R3 refill on drain", DW'(ready), 1);
        tick();
        check(dn_valid && dn_data == 32'hC0DE_0002, "R3 refilled word", dn_data, 32'hC0DE_0002);
        op = 2'd0;
        tick();
        check(dn_valid == 1'b0, "R5 send drained", DW'(dn_valid), 0);

        // R4 shift forwards the read word
        up_valid = 1'b1; up_data = 32'h5F00_0042; op = 2'd3; #1;
        check(ready == 1'b1, "R4 shift ready", DW'(ready), 1);
        tick();
        up_valid = 1'b0; op = 2'd0;
        check(dn_valid && dn_data == 32'h5F00_0042, "R4 shift forwarded", dn_data, 32'h5F00_0042);
        tick();

        // R8 one word per cycle
        for (int i = 0; i < 8; i++) begin
            up_valid = 1'b1; up_data = 32'h5500_0000 + DW'(i); op = 2'd1; #1;
            check(ready && rdata == 32'h5500_0000 + DW'(i), "R8 streaming get", rdata,
                  32'h5500_0000 + DW'(i));
            tick();
        end
        up_valid = 1'b0; op = 2'd0;
        tick();
        check(up_full == 1'b0, "R8 nothing lodged", DW'(up_full), 0);

        // R9 broadcast on the ring
        do_reset();
        for (int k = 0; k < NODES; k++) step[k] = 0;
        for (int c = 0; c < 200; c++) begin
            bit all_done;
            all_done = 1'b1;
            for (int k = 0; k < NODES; k++) begin
                if (step[k] < NODES) all_done = 1'b0;
                if (step[k] == 0) begin b_op[k] = 2'd2; b_wdata[k] = node_word(k); end
                else if (step[k] < NODES-1) b_op[k] = 2'd3;
                else if (step[k] == NODES-1) b_op[k] = 2'd1;
                else b_op[k] = 2'd0;
            end
            if (all_done) break;
            #1;
            for (int k = 0; k < NODES; k++) begin
                rdy[k] = b_ready[k]; rd[k] = b_rdata[k];
            end
            tick();
            for (int k = 0; k < NODES; k++) begin
                if (rdy[k]) begin
                    if (step[k] > 0) got[k][step[k]-1] = rd[k];
                    step[k]++;
                end
            end
        end
        for (int k = 0; k < NODES; k++) begin
            check(step[k] == NODES, "R9 node finished", DW'(step[k]), DW'(NODES));
            for (int j = 0; j < NODES-1; j++)
                check(got[k][j] == node_word((k - 1 - j + 2*NODES) % NODES), "R9 ring order",
                      got[k][j], node_word((k - 1 - j + 2*NODES) % NODES));
        end
        tick(); tick();
        for (int k = 0; k < NODES; k++)
            check(!b_up_full[k] && !b_dn_valid[k], "R9 ring empty after broadcast",
                  DW'({b_up_full[k], b_dn_valid[k]}), 0);

        report();
        $finish;
    end

endmodule